// File: doc/BRIEF.md
# Load-Use Interlock with Delayed ALU

This block decides, cycle by cycle, whether the instruction sitting in the decode (ID) stage of an in-order ID, E1, E2, E3, WB pipeline may advance. Load data is ready only at the end of E3. The block keeps a compact record of what occupies E1 through WB. It compares the ID instruction's enabled source registers against the destinations of loads still in flight. It raises a stall for exactly as many cycles as the consumer needs so that its operand-use stage coincides with the load sitting in WB, where the E3 result is forwarded. Each stall cycle places a bubble in E1 while ID and the front end hold.

A mode input selects when ALU instructions read their operands. In conventional timing they read them in E1. In delayed timing they read them in E2, one stage later, which trims the back-to-back load-use penalty from two cycles to one. Load instructions compute their address early, so a load whose base register comes from an older load always reads it in E1, whatever the mode. The block also drives the forwarding selects for the E1 and E2 operand muxes, one bit per source operand.

Top module: `ldi_interlock`

## Requirements
- R1: While rst_ni is low and right after it rises, stall_o, e1_valid_o, fwd_e1_o and fwd_e2_o are all 0.
- R2: With mode_delayed_i=0, a non-load instruction whose enabled source equals the destination of a load issued on the previous accepted slot sees stall_o high for exactly 2 cycles.
- R3: With mode_delayed_i=1, the same back-to-back sequence sees stall_o high for exactly 1 cycle.
- R4: With g valid non-load, sourceless instructions between the load and its consumer, the stall count is max(0, 2-g) in conventional mode and max(0, 1-g) in delayed mode.
- R5: A load (id_is_load_i=1) whose enabled source matches an in-flight load destination stalls as an E1 user in both modes: max(0, 2-g) cycles.
- R6: Every cycle with stall_o high is followed by a cycle with e1_valid_o low; with no stall, a valid ID instruction appears in E1 (e1_valid_o=1) in the next cycle.
- R7: fwd_e1_o[s] (or fwd_e2_o[s] for delayed ALU users) is high for one cycle when that operand's stage holds the consumer and WB holds the matching load. This happens iff g is at most 2 (E1 users) or at most 1 (delayed users). Bit s is the source index, and source s occupies id_src_i bits [s*5 +: 5].
- R8: No stall occurs when id_valid_i is 0, when no source is enabled, when the sources match no in-flight load, or when the only matching older writer is not a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_delayed_i | input | 1 | 1: ALU operands read in E2; 0: read in E1 |
| id_valid_i | input | 1 | ID holds a valid instruction |
| id_is_load_i | input | 1 | ID instruction is a load |
| id_dst_i | input | 5 | ID destination register |
| id_src_i | input | 10 | ID source registers, source s at bits [s*5 +: 5] |
| id_src_en_i | input | 2 | Per-source enable |
| stall_o | output | 1 | Hold ID and earlier stages, insert bubble in E1 |
| e1_valid_o | output | 1 | E1 holds a valid instruction (0 = bubble) |
| fwd_e1_o | output | 2 | Per-source select of load data for the E1 operand mux |
| fwd_e2_o | output | 2 | Per-source select of load data for the E2 operand mux |

## Verification
The main function is driven by a load followed by zero to three filler instructions and then a consumer. Running this sweep in both modes separates the two-cycle and one-cycle penalties and shows where each falls to zero. Load consumers run in delayed mode to confirm that address operands keep early timing. Consumers on the second operand slot, with unrelated sources and with no sources, tell apart a register match on the right operand, a false match, and the no-source case. Bubble counts and forward-select counts per sequence confirm that stalls turn into E1 bubbles, and that the forward arrives in the correct stage's mux exactly once.

// File: rtl/ldi_pkg.sv
package ldi_pkg;
  parameter int unsigned REG_W = 5;
  parameter int unsigned NSRC  = 2;

  // tracked stages: E1, E2, E3, WB
  localparam int unsigned NSLOT   = 4;
  localparam int unsigned E1_IDX  = 0;
  localparam int unsigned E2_IDX  = 1;
  localparam int unsigned WB_IDX  = NSLOT - 1;
  // cycles from ID until operand use
  localparam int unsigned LAG_EARLY = 1;
  localparam int unsigned LAG_LATE  = 2;

  typedef struct packed {
    logic                       valid;
    logic                       is_load;
    logic                       use_early;
    logic [NSRC-1:0]            src_en;
    logic [NSRC-1:0][REG_W-1:0] src;
    logic [REG_W-1:0]           dst;
  } slot_t;

  // load in stage st_idx blocks a consumer in ID if it reaches WB after the consumer reaches its use stage
  function automatic logic load_blocks(input int unsigned st_idx, input logic use_early);
    int unsigned to_ready;
    int unsigned to_use;
    to_ready = WB_IDX - st_idx;
    to_use   = use_early ? LAG_EARLY : LAG_LATE;
    return to_ready > to_use;
  endfunction
endpackage

// File: rtl/ldi_src_cmp.sv
module ldi_src_cmp
  import ldi_pkg::*;
(
  input  slot_t id_slot_i,
  input  slot_t stage_i [NSLOT],
  output logic  hazard_o
);
  logic [NSRC*NSLOT-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
      assign hit[s*NSLOT+j] = id_slot_i.src_en[s]
                            && stage_i[j].valid && stage_i[j].is_load
                            && (stage_i[j].dst == id_slot_i.src[s])
                            && load_blocks(j, id_slot_i.use_early);
    end
  end

  assign hazard_o = |hit;
endmodule

// File: rtl/ldi_shadow_pipe.sv
module ldi_shadow_pipe
  import ldi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stall_i,
  input  slot_t id_slot_i,
  output slot_t stage_o [NSLOT]
);
  slot_t stage_q [NSLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stage_q[E1_IDX] <= '0;
    else if (stall_i)  stage_q[E1_IDX] <= '0;  // bubble
    else               stage_q[E1_IDX] <= id_slot_i;
  end

  for (genvar j = 1; j < NSLOT; j++) begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[j] <= '0;
      else         stage_q[j] <= stage_q[j-1];
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/ldi_fwd_sel.sv
module ldi_fwd_sel
  import ldi_pkg::*;
#(
  parameter logic EARLY = 1'b1
) (
  input  slot_t           user_i,
  input  slot_t           wb_i,
  output logic [NSRC-1:0] sel_o
);
  for (genvar s = 0; s < NSRC; s++) begin : g_sel
    assign sel_o[s] = user_i.valid && (user_i.use_early == EARLY) && user_i.src_en[s]
                   && wb_i.valid && wb_i.is_load && (wb_i.dst == user_i.src[s]);
  end
endmodule

// File: rtl/ldi_interlock.sv
module ldi_interlock
  import ldi_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_delayed_i,
  input  logic                  id_valid_i,
  input  logic                  id_is_load_i,
  input  logic [REG_W-1:0]      id_dst_i,
  input  logic [NSRC*REG_W-1:0] id_src_i,
  input  logic [NSRC-1:0]       id_src_en_i,
  output logic                  stall_o,
  output logic                  e1_valid_o,
  output logic [NSRC-1:0]       fwd_e1_o,
  output logic [NSRC-1:0]       fwd_e2_o
);
  slot_t id_slot;
  slot_t stage [NSLOT];
  logic  hazard;
  logic  unused_wb;

  always_comb begin
    id_slot           = '0;
    id_slot.valid     = id_valid_i;
    id_slot.is_load   = id_is_load_i;
    id_slot.use_early = id_is_load_i | ~mode_delayed_i;  // address calc stays early
    id_slot.src_en    = id_src_en_i;
    id_slot.src       = id_src_i;
    id_slot.dst       = id_dst_i;
  end

  ldi_src_cmp u_cmp (
    .id_slot_i (id_slot),
    .stage_i   (stage),
    .hazard_o  (hazard)
  );

  assign stall_o = id_valid_i & hazard;

  ldi_shadow_pipe u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall_o),
    .id_slot_i (id_slot),
    .stage_o   (stage)
  );

  ldi_fwd_sel #(.EARLY(1'b1)) u_fwd_e1 (
    .user_i (stage[E1_IDX]),
    .wb_i   (stage[WB_IDX]),
    .sel_o  (fwd_e1_o)
  );

  ldi_fwd_sel #(.EARLY(1'b0)) u_fwd_e2 (
    .user_i (stage[E2_IDX]),
    .wb_i   (stage[WB_IDX]),
    .sel_o  (fwd_e2_o)
  );

  assign e1_valid_o = stage[E1_IDX].valid;
  assign unused_wb  = ^{stage[WB_IDX].src, stage[WB_IDX].src_en, stage[WB_IDX].use_early};
endmodule

// File: rtl/ldi_interlock_chk.sv
module ldi_interlock_chk
  import ldi_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_delayed_i,
  input logic            id_valid_i,
  input logic            id_is_load_i,
  input logic [NSRC-1:0] id_src_en_i,
  input logic            stall_o,
  input logic            e1_valid_o,
  input logic [NSRC-1:0] fwd_e1_o,
  input logic [NSRC-1:0] fwd_e2_o
);
  // R6
  stall_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !e1_valid_o);

  // R2
  max_two_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stall_o) && $past(stall_o, 2)) |-> !stall_o);

  // R3
  late_one_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_delayed_i && !id_is_load_i && stall_o) |=> !(mode_delayed_i && !id_is_load_i && stall_o));

  // R8
  no_src_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && (id_src_en_i == '0)) |-> !stall_o);

  // R7
  fwd_e1_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fwd_e1_o) |-> e1_valid_o);

  // R7
  fwd_e2_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fwd_e2_o) |-> $past(e1_valid_o));
endmodule

bind ldi_interlock ldi_interlock_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_delayed_i (mode_delayed_i),
  .id_valid_i     (id_valid_i),
  .id_is_load_i   (id_is_load_i),
  .id_src_en_i    (id_src_en_i),
  .stall_o        (stall_o),
  .e1_valid_o     (e1_valid_o),
  .fwd_e1_o       (fwd_e1_o),
  .fwd_e2_o       (fwd_e2_o)
);

// File: tb/ldi_interlock_tb.sv
`timescale 1ns/1ps
module ldi_interlock_tb;
  import ldi_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  mode_delayed = 1'b0;
  logic                  id_valid = 1'b0;
  logic                  id_is_load = 1'b0;
  logic [REG_W-1:0]      id_dst = '0;
  logic [NSRC*REG_W-1:0] id_src = '0;
  logic [NSRC-1:0]       id_src_en = '0;
  logic                  stall;
  logic                  e1_valid;
  logic [NSRC-1:0]       fwd_e1;
  logic [NSRC-1:0]       fwd_e2;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldi_interlock u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .mode_delayed_i (mode_delayed),
    .id_valid_i     (id_valid),
    .id_is_load_i   (id_is_load),
    .id_dst_i       (id_dst),
    .id_src_i       (id_src),
    .id_src_en_i    (id_src_en),
    .stall_o        (stall),
    .e1_valid_o     (e1_valid),
    .fwd_e1_o       (fwd_e1),
    .fwd_e2_o       (fwd_e2)
  );

  // {mode, kind, gap, slot, stalls, f1, f2}; kind 0 alu, 1 load, 2 unrelated src, 3 no src
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_00_00_0_10_1_0,  // R2
    10'b0_00_01_0_01_1_0,  // R4
    10'b0_00_10_0_00_1_0,  // R4
    10'b0_00_11_0_00_0_0,  // R4
    10'b1_00_00_0_01_0_1,  // R3
    10'b1_00_01_0_00_0_1,  // R4
    10'b1_00_10_0_00_0_0,  // R4
    10'b1_01_00_0_10_1_0,  // R5
    10'b1_01_01_0_01_1_0,  // R5
    10'b1_10_00_0_00_0_0,  // R8
    10'b0_11_00_0_00_0_0,  // R8
    10'b1_00_00_1_01_0_1   // R3 second operand
  };

  logic mon_en = 0;
  logic mon_sl = 0;
  int bub_cnt, f1_cnt, f2_cnt, oth_cnt;

  always @(negedge clk) if (mon_en) begin
    if (!e1_valid) bub_cnt++;
    if (fwd_e1[mon_sl]) f1_cnt++;
    if (fwd_e2[mon_sl]) f2_cnt++;
    if (fwd_e1[!mon_sl] || fwd_e2[!mon_sl]) oth_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      id_valid = 0; id_is_load = 0; id_src_en = '0;
    end
  endtask

  // drive one instruction, hold while stalled, return stall cycles
  task automatic issue(input logic ld, input logic [NSRC-1:0] en,
                       input logic [REG_W-1:0] s0, input logic [REG_W-1:0] s1,
                       input logic [REG_W-1:0] dst, output int stalls);
    @(negedge clk);
    id_valid = 1; id_is_load = ld; id_src_en = en;
    id_src = {s1, s0}; id_dst = dst;
    #1;
    stalls = 0;
    while (stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic nop();
    int st;
    issue(1'b0, 2'b00, 5'd0, 5'd0, 5'd1, st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int st;
    logic [9:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 stall in reset", int'(stall), 0);
    chk("R1 e1_valid in reset", int'(e1_valid), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 stall after reset", int'(stall), 0);
    chk("R1 e1_valid after reset", int'(e1_valid), 0);
    chk("R1 fwd after reset", int'({fwd_e1, fwd_e2}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [NSRC-1:0] en;
      logic [REG_W-1:0] s0, s1;
      v = VEC[i];
      idle(4);
      mode_delayed = v[9];
      mon_sl = v[4];
      bub_cnt = 0; f1_cnt = 0; f2_cnt = 0; oth_cnt = 0;
      issue(1'b1, 2'b01, 5'd2, 5'd0, 5'd5, st);  // load r5
      mon_en = 1;
      for (int g = 0; g < int'(v[6:5]); g++) nop();
      s0 = 5'd7; s1 = 5'd7; en = 2'b01;
      case (v[8:7])
        2'd0, 2'd1: begin
          en = v[4] ? 2'b10 : 2'b01;
          if (v[4]) s1 = 5'd5; else s0 = 5'd5;
        end
        2'd2: s0 = 5'd6;
        default: begin en = 2'b00; s0 = 5'd5; end
      endcase
      issue(v[8:7] == 2'd1, en, s0, s1, 5'd9, st);
      for (int k = 0; k < 4; k++) nop();
      @(negedge clk); #2;
      mon_en = 0;
      chk($sformatf("R2/R3/R4/R5/R8 stalls vec %0d", i), st, int'(v[3:2]));
      chk($sformatf("R6 bubbles vec %0d", i), bub_cnt, int'(v[3:2]));
      chk($sformatf("R7 fwd_e1 vec %0d", i), f1_cnt, int'(v[1]));
      chk($sformatf("R7 fwd_e2 vec %0d", i), f2_cnt, int'(v[0]));
      chk($sformatf("R7 other operand vec %0d", i), oth_cnt, 0);
    end

    // R8: invalid ID slot with a matching source
    idle(4);
    mode_delayed = 0;
    issue(1'b1, 2'b01, 5'd2, 5'd0, 5'd5, st);
    @(negedge clk);
    id_valid = 0; id_is_load = 0; id_src_en = 2'b01; id_src = {5'd0, 5'd5};
    #1;
    chk("R8 invalid ID no stall", int'(stall), 0);

    // R8: older non-load writer of the same register
    idle(4);
    issue(1'b0, 2'b00, 5'd0, 5'd0, 5'd5, st);
    issue(1'b0, 2'b01, 5'd5, 5'd0, 5'd9, st);
    chk("R8 non-load writer no stall", st, 0);

    // R6: no stall, valid instruction lands in E1
    @(negedge clk); #1;
    chk("R6 e1 valid after accept", int'(e1_valid), 1);

    // R1: reset mid-stream clears the tracked pipe
    issue(1'b1, 2'b01, 5'd2, 5'd0, 5'd5, st);
    @(negedge clk);
    id_valid = 0;
    rst_n = 0;
    #1;
    chk("R1 e1_valid cleared by reset", int'(e1_valid), 0);
    @(negedge clk);
    rst_n = 1;
    id_valid = 1; id_is_load = 0; id_src_en = 2'b01; id_src = {5'd0, 5'd5};
    #1;
    chk("R1 no stall after reset", int'(stall), 0);
    idle(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule